// File: doc/BRIEF.md
# Two-Cycle Pipelined Arithmetic/Logic Unit

This block is a clocked arithmetic and logic unit for two unsigned operands. When the issue strobe is high on a rising clock edge, the unit samples a two-bit operation selector and both operands. Two edges later it presents the result, zero-extended to twice the operand width, on its single output.

The unit supports four operations: add, unsigned multiply, bitwise OR and bitwise AND. The pipeline has no stalls, so a new operation may be issued on every cycle. The interface is intentionally plain strobe-and-data: there is no ready signal and no back-pressure. The consumer must sample the result on the cycle its own issue schedule predicts. Between completions the output keeps its last value.

Top module: `alu_pipe2`

## Requirements
- R1: On a rising edge with `issue` = 1, the values of `opsel`, `lhs` and `rhs` are captured. Later changes to those inputs do not affect that operation.
- R2: The result of a captured operation appears on `result` after the second rising edge that follows the capturing edge, counting the capturing edge as edge 0.
- R3: The operation is selected by `opsel`: 2'b00 is add, 2'b01 is multiply, 2'b10 is bitwise OR, and 2'b11 is bitwise AND.
- R4: For add, `result` holds the 9-bit sum including the carry in bits 8:0. Bits 15:9 are zero.
- R5: For OR and AND, `result` holds the 8-bit value in bits 7:0. Bits 15:8 are zero.
- R6: For multiply, `result` holds the full unsigned 16-bit product.
- R7: An operation may be issued on every cycle. Each result appears exactly two edges after its own issue, in issue order.
- R8: When `issue` = 0 at an edge, the inputs at that edge are ignored. `result` keeps the most recently completed value until a newer operation completes.
- R9: A synchronous active-high `rst` clears all pending operations and drives `result` to zero on the next edge. Operations that were in flight when reset was applied never appear.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Capture strobe for a new operation |
| opsel | input | 2 | Operation selector |
| lhs | input | 8 | First unsigned operand |
| rhs | input | 8 | Second unsigned operand |
| result | output | 16 | Zero-extended result |

## Verification
The hardest behaviour to reach from the ports is the interaction of reset with operations already in flight. It requires issues on the edges just before reset, and then a check that none of those results ever surfaces afterwards. The bench forces this with a directed sequence: it issues two operations back to back, asserts reset, and then holds `issue` low so that any leaked result would show up on the output. Randomized issue density is mixed with idle gaps, so hold behaviour and full-rate issue are both exercised. Directed all-ones operands hit the carry bit and the maximum product.

// File: rtl/alu_pipe2_pkg.sv
package alu_pipe2_pkg;
  typedef enum logic [1:0] {
    OPS_ADD = 2'b00,
    OPS_MUL = 2'b01,
    OPS_IOR = 2'b10,
    OPS_AND = 2'b11
  } opsel_e;
endpackage

// File: rtl/alu_capture.sv
module alu_capture #(
  parameter int OPW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue,
  input  alu_pipe2_pkg::opsel_e    opsel,
  input  logic [OPW-1:0]           lhs,
  input  logic [OPW-1:0]           rhs,
  output logic                     cap_vld,
  output alu_pipe2_pkg::opsel_e    cap_op,
  output logic [OPW-1:0]           cap_lhs,
  output logic [OPW-1:0]           cap_rhs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld <= 1'b0;
      cap_op  <= alu_pipe2_pkg::OPS_ADD;
      cap_lhs <= '0;
      cap_rhs <= '0;
    end else begin
      cap_vld <= issue;
      if (issue) begin
        cap_op  <= opsel;
        cap_lhs <= lhs;
        cap_rhs <= rhs;
      end
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    issue |=> (cap_vld && cap_lhs == $past(lhs) && cap_rhs == $past(rhs)));
endmodule

// File: rtl/alu_compute.sv
module alu_compute #(
  parameter int OPW = 8,
  localparam int RW = 2*OPW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_vld,
  input  alu_pipe2_pkg::opsel_e    cap_op,
  input  logic [OPW-1:0]           cap_lhs,
  input  logic [OPW-1:0]           cap_rhs,
  output logic                     cmp_vld,
  output logic [RW-1:0]            cmp_val
);
  import alu_pipe2_pkg::*;
  logic [RW-1:0] nxt;

  always_comb begin
    unique case (cap_op)
      OPS_ADD: nxt = RW'({1'b0, cap_lhs} + {1'b0, cap_rhs});
      OPS_MUL: nxt = RW'(cap_lhs) * RW'(cap_rhs);
      OPS_IOR: nxt = RW'(cap_lhs | cap_rhs);
      default: nxt = RW'(cap_lhs & cap_rhs);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_vld <= 1'b0;
      cmp_val <= '0;
    end else begin
      cmp_vld <= cap_vld;
      if (cap_vld) cmp_val <= nxt;
    end
  end

  p_add_width_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_op == OPS_ADD) |=> (cmp_val[RW-1:OPW+1] == '0));
  p_logic_width_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_op[1]) |=> (cmp_val[RW-1:OPW] == '0));
endmodule

// File: rtl/alu_result.sv
module alu_result #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_vld,
  input  logic [RW-1:0] cmp_val,
  output logic [RW-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (cmp_vld) result <= cmp_val;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cmp_vld |=> $stable(result));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (result == '0));
endmodule

// File: rtl/alu_pipe2.sv
module alu_pipe2 #(
  parameter int OPW = 8,
  localparam int RW = 2*OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic [1:0]     opsel,
  input  logic [OPW-1:0] lhs,
  input  logic [OPW-1:0] rhs,
  output logic [RW-1:0]  result
);
  import alu_pipe2_pkg::*;
  logic           cap_vld, cmp_vld;
  opsel_e         cap_op;
  logic [OPW-1:0] cap_lhs, cap_rhs;
  logic [RW-1:0]  cmp_val;

  alu_capture #(.OPW(OPW)) u_cap (
    .clk(clk), .rst(rst), .issue(issue), .opsel(opsel_e'(opsel)),
    .lhs(lhs), .rhs(rhs), .cap_vld(cap_vld), .cap_op(cap_op),
    .cap_lhs(cap_lhs), .cap_rhs(cap_rhs));

  alu_compute #(.OPW(OPW)) u_cmp (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_op(cap_op),
    .cap_lhs(cap_lhs), .cap_rhs(cap_rhs), .cmp_vld(cmp_vld), .cmp_val(cmp_val));

  alu_result #(.RW(RW)) u_res (
    .clk(clk), .rst(rst), .cmp_vld(cmp_vld), .cmp_val(cmp_val), .result(result));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    cap_vld |=> cmp_vld);
endmodule

// File: tb/alu_pipe2_tb.sv
module alu_pipe2_tb;
  logic clk = 1'b0;
  logic rst, issue;
  logic [1:0] opsel;
  logic [7:0] lhs, rhs;
  logic [15:0] result;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // model slots: s0 after capture edge, s1 one edge later
  bit s0v, s1v;
  logic [15:0] s0r, s1r, exp_res;
  string tag;

  always #2 clk = ~clk;

  alu_pipe2 u_dut (.clk(clk), .rst(rst), .issue(issue), .opsel(opsel),
                   .lhs(lhs), .rhs(rhs), .result(result));

  function automatic logic [15:0] ref_op(logic [1:0] o, logic [7:0] a, logic [7:0] b);
    case (o)
      2'b00: return {7'd0, 9'(a) + 9'(b)};   // R3 R4
      2'b01: return 16'(a) * 16'(b);         // R3 R6
      2'b10: return {8'd0, a | b};           // R3 R5
      default: return {8'd0, a & b};         // R3 R5
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: result=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, clock one edge, update model, check at next negedge
  task automatic step(bit r, bit s, logic [1:0] o, logic [7:0] a, logic [7:0] b);
    rst = r; issue = s; opsel = o; lhs = a; rhs = b;
    @(posedge clk);
    #1;
    if (r) begin
      s0v = 0; s1v = 0; exp_res = 0;
    end else begin
      if (s1v) exp_res = s1r;
      s1v = s0v; s1r = s0r;
      s0v = s; s0r = ref_op(o, a, b);
    end
    // scramble inputs after capture (R1)
    lhs = ~a; rhs = ~b; opsel = ~o;
    @(negedge clk);
    check(tag, result, exp_res);
  endtask

  initial begin
    rst = 1; issue = 0; opsel = 0; lhs = 0; rhs = 0;
    s0v = 0; s1v = 0; exp_res = 0; s0r = 0; s1r = 0;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    tag = "R9 reset";
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    // directed corners
    tag = "R4 add carry";   step(0, 1, 2'b00, 8'hFF, 8'hFF);
    tag = "R6 max product"; step(0, 1, 2'b01, 8'hFF, 8'hFF);
    tag = "R5 or";          step(0, 1, 2'b10, 8'hF0, 8'h0F);
    tag = "R5 and";         step(0, 1, 2'b11, 8'hFF, 8'hA5);
    tag = "R8 idle hold";   step(0, 0, 2'b01, 8'h12, 8'h34);
    step(0, 0, 2'b01, 8'h55, 8'h66);
    step(0, 0, 2'b00, 8'h77, 8'h88);
    if (exp_res !== 16'h00A5) begin
      n_chk++; n_bad++;
      $display("FAIL R2 model: result=%h expected=%h", exp_res, 16'h00A5);
    end
    // reset with operations in flight (R9)
    tag = "R7 back-to-back"; step(0, 1, 2'b01, 8'd10, 8'd20);
    step(0, 1, 2'b00, 8'd3, 8'd4);
    tag = "R9 flush";        step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // random mix: R2 R3 R7 R8
    tag = "R2 random";
    for (int i = 0; i < 400; i++) begin
      bit s = ($urandom_range(0, 9) < 7);
      step(0, s, 2'($urandom), 8'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%h expected=done", result);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule